// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

The sequencer takes DMA read and write requests with any byte address and any length up to a configured maximum. It cuts each one into pieces that never cross a cache-line boundary and sends those pieces to a memory port one at a time. Up to `DEPTH` requests are tracked at once in a small table. Each table entry holds the start address, the total length, two progress counters (bytes issued, bytes completed) and a byte buffer. For a write the buffer holds the write data. For a read it collects the returned bytes.

A request is answered in the same cycle with a status code. Accepted requests produce line chunks on a valid/ready memory request port. Memory answers on a response port that carries the chunk's line address. A store response is a plain acknowledgement, and a load response carries the full line of data. When the final chunk of a request is answered, the entry is released and a one-cycle completion pulse reports the request's line address, its length, its direction and its buffer contents.

Top module: `dma_line_splitter`

## Requirements
- R1: A request made while the number of busy table entries equals `MAX_OUT` gets status 1 (full) and is not stored. A request with status 0 (issued) is stored in the lowest-numbered free entry.
- R2: A request whose line address (its address with the low log2(`LINE_BYTES`) bits cleared) equals the line address of a busy entry's start gets status 2 (aliased). No chunk is issued for it, and no two busy entries ever share a start line.
- R3: A request of length 0 or of length above `MAX_LEN` gets status 3 (bad length) and is not stored. The checks run in this priority order: bad length, then full, then aliased.
- R4: The first chunk of a request has the request's own byte address. Its length is the smaller of the request length and `LINE_BYTES` minus the address offset within the line.
- R5: Every later chunk starts at the start address plus the bytes already completed, which is line-aligned. Its length is the smaller of the remaining bytes and `LINE_BYTES`.
- R6: `mreq_store` is 1 for a write request and 0 for a read request. `mreq_line` equals `mreq_addr` with its offset bits cleared.
- R7: For a write chunk, payload byte j (byte j sits at bits 8j+7..8j) carries request data byte (completed + j − offset), for j from offset to offset+length−1. All other payload bytes are zero. A read chunk's payload is all zero.
- R8: For a read, response byte (offset + k) lands in buffer byte (completed + k) for k below bytes issued minus bytes completed. The offset is used only while completed is zero. At completion, `done_rdata` byte i equals memory byte (start + i) for i below the length, and is zero above it.
- R9: A response to the final chunk releases the entry. One cycle later `done_valid` pulses for exactly one cycle with the start line, the length and the direction. A new request to the same line is then accepted.
- R10: A request has at most one chunk in flight. Its next chunk is offered only after the response to the previous one.
- R11: While `mreq_valid` is high and `mreq_ready` is low, the offered chunk stays the same, and no request state is lost.
- R12: When several entries have a chunk ready, the lowest table index is offered first.
- R13: A response whose line matches no in-flight chunk sets `stray_err`, which stays set until reset. Such a response changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start byte address |
| req_len | input | LENW | Length in bytes |
| req_wdata | input | MAX_LEN*8 | Write data, byte i at bits 8i+7..8i |
| req_status | output | 2 | 0 issued, 1 full, 2 aliased, 3 bad length (same cycle) |
| mreq_valid | output | 1 | Chunk offered |
| mreq_ready | input | 1 | Memory takes the chunk |
| mreq_store | output | 1 | Chunk is a store |
| mreq_addr | output | AW | Chunk byte address |
| mreq_line | output | AW | Chunk line address |
| mreq_len | output | LENW | Chunk length in bytes |
| mreq_data | output | LINE_BYTES*8 | Store payload placed at line offsets |
| mrsp_valid | input | 1 | Response present |
| mrsp_line | input | AW | Line address of the answered chunk |
| mrsp_data | input | LINE_BYTES*8 | Line data for loads |
| done_valid | output | 1 | Completion pulse |
| done_write | output | 1 | Direction of completed request |
| done_line | output | AW | Start line of completed request |
| done_len | output | LENW | Length of completed request |
| done_rdata | output | MAX_LEN*8 | Buffer of completed request |
| stray_err | output | 1 | Sticky unmatched-response flag |

## Verification
Every cycle, the assertions check the following. The outstanding count never passes its limit. Busy entries never share a start line. A chunk that is being offered fits inside one line and is non-empty, and any chunk after the first is aligned. The offer stays fixed under back-pressure, and the grant is one-hot and only goes to an entry that wants it. A response only reaches an entry that has a chunk in flight, and the stray flag never clears. Only the bench scenarios can show the arithmetic results. These are the chunk addresses and lengths across every offset and length of a small line, the placement of the write payload, the gathering of read bytes into request order, the status priority, the service order among waiting entries, and completion after responses arrive out of order.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   typedef enum logic [1:0] {
      ST_ISSUED  = 2'd0,
      ST_FULL    = 2'd1,
      ST_ALIASED = 2'd2,
      ST_BADLEN  = 2'd3
   } dsq_status_e;
endpackage

// File: rtl/dsq_chunk_calc.sv
module dsq_chunk_calc #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int LENW       = 8
) (
   input  logic [AW-1:0]   start_addr,
   input  logic [LENW-1:0] total_len,
   input  logic [LENW-1:0] done_bytes,
   output logic [AW-1:0]   chunk_addr,
   output logic [AW-1:0]   chunk_line,
   output logic [$clog2(LINE_BYTES)-1:0] chunk_off,
   output logic [LENW-1:0] chunk_len
);
   localparam int OFFW = $clog2(LINE_BYTES);
   localparam int CW   = (LENW > OFFW + 1) ? LENW : OFFW + 1;

   logic [CW-1:0] remain, room;

   always_comb begin
      chunk_off  = (done_bytes == '0) ? start_addr[OFFW-1:0] : '0;
      chunk_addr = start_addr + AW'(done_bytes);
      chunk_line = {chunk_addr[AW-1:OFFW], {OFFW{1'b0}}};
      remain     = CW'(total_len) - CW'(done_bytes);
      room       = CW'(LINE_BYTES) - CW'(chunk_off);
      chunk_len  = LENW'((remain < room) ? remain : room);
   end
endmodule

// File: rtl/dsq_issue_arb.sv
module dsq_issue_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] want,
   input  logic         ready,
   output logic [N-1:0] grant
);
   logic [N-1:0] held_q, pick;

   always_comb begin
      pick = '0;
      for (int k = N - 1; k >= 0; k--)
         if (want[k]) pick = N'(1) << k;
      grant = (|held_q) ? held_q : pick;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)               held_q <= '0;
      else if (|grant && !ready) held_q <= grant;
      else                       held_q <= '0;
   end

   a_r12_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   a_r10_grant_wanted: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~want) == '0);
   a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant && !ready) |=> (grant == $past(grant)));
endmodule

// File: rtl/dsq_entry.sv
module dsq_entry #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 128,
   parameter int LENW       = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc,
   input  logic                    alloc_write,
   input  logic [AW-1:0]           alloc_addr,
   input  logic [LENW-1:0]         alloc_len,
   input  logic [MAX_LEN*8-1:0]    alloc_wdata,
   input  logic                    issue_fire,
   input  logic                    rsp_hit,
   input  logic [LINE_BYTES*8-1:0] rsp_data,
   output logic                    busy,
   output logic                    want,
   output logic                    is_write,
   output logic [AW-1:0]           key_line,
   output logic [AW-1:0]           cur_addr,
   output logic [AW-1:0]           cur_line,
   output logic [LENW-1:0]         cur_len,
   output logic [LINE_BYTES*8-1:0] payload,
   output logic                    finishing,
   output logic [LENW-1:0]         tot_len,
   output logic [MAX_LEN*8-1:0]    merged
);
   localparam int OFFW = $clog2(LINE_BYTES);

   logic                 busy_q, pend_q, wr_q;
   logic [AW-1:0]        start_q;
   logic [LENW-1:0]      tot_q, done_q, iss_q;
   logic [MAX_LEN*8-1:0] buf_q, buf_init;
   logic [OFFW-1:0]      c_off;

   dsq_chunk_calc #(.AW(AW), .LINE_BYTES(LINE_BYTES), .LENW(LENW)) u_calc (
      .start_addr(start_q), .total_len(tot_q), .done_bytes(done_q),
      .chunk_addr(cur_addr), .chunk_line(cur_line), .chunk_off(c_off),
      .chunk_len(cur_len));

   assign busy      = busy_q;
   assign want      = busy_q & pend_q;
   assign is_write  = wr_q;
   assign key_line  = {start_q[AW-1:OFFW], {OFFW{1'b0}}};
   assign finishing = (iss_q == tot_q);
   assign tot_len   = tot_q;

   // store payload: request bytes placed at their line offsets
   always_comb begin
      payload = '0;
      for (int j = 0; j < LINE_BYTES; j++)
         if (wr_q && j >= int'(c_off) && j < int'(c_off) + int'(cur_len))
            payload[j*8 +: 8] = 8'(buf_q >> (8 * (int'(done_q) + j - int'(c_off))));
   end

   // load gather: bytes of the in-flight chunk move into request order
   always_comb begin
      merged = buf_q;
      if (!wr_q)
         for (int b = 0; b < MAX_LEN; b++)
            if (b >= int'(done_q) && b < int'(iss_q))
               merged[b*8 +: 8] = 8'(rsp_data >> (8 * (b - int'(done_q) + int'(c_off))));
   end

   always_comb
      for (int i = 0; i < MAX_LEN; i++)
         buf_init[i*8 +: 8] = (alloc_write && i < int'(alloc_len)) ? alloc_wdata[i*8 +: 8] : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0; pend_q <= 1'b0; wr_q <= 1'b0; start_q <= '0;
         tot_q <= '0; done_q <= '0; iss_q <= '0; buf_q <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1; pend_q <= 1'b1; wr_q <= alloc_write;
         start_q <= alloc_addr; tot_q <= alloc_len;
         done_q <= '0; iss_q <= '0; buf_q <= buf_init;
      end else begin
         if (issue_fire) begin
            iss_q  <= iss_q + cur_len;
            pend_q <= 1'b0;
         end
         if (rsp_hit) begin
            done_q <= iss_q;
            buf_q  <= merged;
            if (finishing) busy_q <= 1'b0;
            else           pend_q <= 1'b1;
         end
      end
   end

   a_r10_rsp_inflight: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (busy_q && !pend_q));
   a_r10_issue_pending: assert property (@(posedge clk) disable iff (!rst_n)
      issue_fire |-> (busy_q && pend_q));
   a_r4_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
      want |-> (cur_len != '0 && int'(c_off) + int'(cur_len) <= LINE_BYTES));
   a_r5_later_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (want && done_q != '0) |-> (cur_addr[OFFW-1:0] == '0));
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && finishing && !alloc) |=> !busy_q);
endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
   import dsq_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LEN    = 128,
   parameter int DEPTH      = 4,
   parameter int MAX_OUT    = 4,
   localparam int LENW      = $clog2(MAX_LEN + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic [AW-1:0]           req_addr,
   input  logic [LENW-1:0]         req_len,
   input  logic [MAX_LEN*8-1:0]    req_wdata,
   output logic [1:0]              req_status,
   output logic                    mreq_valid,
   input  logic                    mreq_ready,
   output logic                    mreq_store,
   output logic [AW-1:0]           mreq_addr,
   output logic [AW-1:0]           mreq_line,
   output logic [LENW-1:0]         mreq_len,
   output logic [LINE_BYTES*8-1:0] mreq_data,
   input  logic                    mrsp_valid,
   input  logic [AW-1:0]           mrsp_line,
   input  logic [LINE_BYTES*8-1:0] mrsp_data,
   output logic                    done_valid,
   output logic                    done_write,
   output logic [AW-1:0]           done_line,
   output logic [LENW-1:0]         done_len,
   output logic [MAX_LEN*8-1:0]    done_rdata,
   output logic                    stray_err
);
   localparam int OFFW = $clog2(LINE_BYTES);
   localparam int CNTW = $clog2(DEPTH + 1);

   initial begin
      assert (LINE_BYTES == (1 << OFFW) && LINE_BYTES >= 2)
         else $error("LINE_BYTES must be a power of two");
      assert (MAX_OUT >= 1 && MAX_OUT <= DEPTH)
         else $error("MAX_OUT must lie in 1..DEPTH");
   end

   logic [DEPTH-1:0]           busy, want, wr, fin, alloc, grant, fire, hit;
   logic [AW-1:0]              e_key [DEPTH], e_addr [DEPTH], e_line [DEPTH];
   logic [LENW-1:0]            e_len [DEPTH], e_tot [DEPTH];
   logic [LINE_BYTES*8-1:0]    e_pay [DEPTH];
   logic [MAX_LEN*8-1:0]       e_mrg [DEPTH];
   logic [CNTW-1:0]            n_busy;
   logic [DEPTH-1:0]           free_oh;
   logic [AW-1:0]              req_line;
   logic                       alias_hit;
   dsq_status_e                st;

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      dsq_entry #(.AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_LEN(MAX_LEN), .LENW(LENW)) u_ent (
         .clk(clk), .rst_n(rst_n), .alloc(alloc[k]), .alloc_write(req_write),
         .alloc_addr(req_addr), .alloc_len(req_len), .alloc_wdata(req_wdata),
         .issue_fire(fire[k]), .rsp_hit(hit[k]), .rsp_data(mrsp_data),
         .busy(busy[k]), .want(want[k]), .is_write(wr[k]), .key_line(e_key[k]),
         .cur_addr(e_addr[k]), .cur_line(e_line[k]), .cur_len(e_len[k]),
         .payload(e_pay[k]), .finishing(fin[k]), .tot_len(e_tot[k]),
         .merged(e_mrg[k]));
   end

   dsq_issue_arb #(.N(DEPTH)) u_arb (
      .clk(clk), .rst_n(rst_n), .want(want), .ready(mreq_ready), .grant(grant));

   assign fire     = grant & {DEPTH{mreq_ready}};
   assign req_line = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};

   // admission: length, then capacity, then aliasing
   always_comb begin
      n_busy    = '0;
      alias_hit = 1'b0;
      free_oh   = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         n_busy = n_busy + CNTW'(busy[k]);
         if (busy[k] && e_key[k] == req_line) alias_hit = 1'b1;
         if (!busy[k]) free_oh = DEPTH'(1) << k;
      end
      if (req_len == '0 || int'(req_len) > MAX_LEN) st = ST_BADLEN;
      else if (int'(n_busy) >= MAX_OUT)             st = ST_FULL;
      else if (alias_hit)                           st = ST_ALIASED;
      else                                          st = ST_ISSUED;
      alloc = (req_valid && st == ST_ISSUED) ? free_oh : '0;
   end
   assign req_status = st;

   // response match against in-flight chunks, lowest index first
   always_comb begin
      hit = '0;
      for (int k = DEPTH - 1; k >= 0; k--)
         if (mrsp_valid && busy[k] && !want[k] && e_line[k] == mrsp_line)
            hit = DEPTH'(1) << k;
   end

   always_comb begin
      mreq_valid = |grant;
      mreq_store = 1'b0; mreq_addr = '0; mreq_line = '0;
      mreq_len   = '0;   mreq_data = '0;
      for (int k = 0; k < DEPTH; k++)
         if (grant[k]) begin
            mreq_store = wr[k];  mreq_addr = e_addr[k]; mreq_line = e_line[k];
            mreq_len   = e_len[k]; mreq_data = e_pay[k];
         end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_valid <= 1'b0; done_write <= 1'b0; done_line <= '0;
         done_len <= '0; done_rdata <= '0; stray_err <= 1'b0;
      end else begin
         done_valid <= |(hit & fin);
         for (int k = 0; k < DEPTH; k++)
            if (hit[k] && fin[k]) begin
               done_write <= wr[k]; done_line <= e_key[k];
               done_len <= e_tot[k]; done_rdata <= e_mrg[k];
            end
         if (mrsp_valid && hit == '0) stray_err <= 1'b1;
      end
   end

   a_r1_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      int'(n_busy) <= MAX_OUT);
   a_r3_badlen_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_len == '0) |-> (alloc == '0));
   a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stray_err |=> stray_err);
   a_r9_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> $past(mrsp_valid));

   for (genvar i = 0; i < DEPTH; i++) begin : g_ua
      for (genvar j = i + 1; j < DEPTH; j++) begin : g_ub
         a_r2_unique_keys: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[i] && busy[j]) |-> (e_key[i] != e_key[j]));
      end
   end
endmodule

// File: tb/tb_dma_line_splitter.sv
`timescale 1ns/1ps
module tb_dma_line_splitter;
   localparam int AW = 16, LB = 8, ML = 20, DP = 4, MO = 3;
   localparam int LENW = $clog2(ML + 1);
   localparam int DW = ML * 8, LW = LB * 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [LENW-1:0] req_len = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_status;
   logic mreq_valid, mreq_ready = 1'b0, mreq_store;
   logic [AW-1:0] mreq_addr, mreq_line;
   logic [LENW-1:0] mreq_len;
   logic [LW-1:0] mreq_data;
   logic mrsp_valid = 1'b0;
   logic [AW-1:0] mrsp_line = '0;
   logic [LW-1:0] mrsp_data = '0;
   logic done_valid, done_write, stray_err;
   logic [AW-1:0] done_line;
   logic [LENW-1:0] done_len;
   logic [DW-1:0] done_rdata;
   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dma_line_splitter #(.AW(AW), .LINE_BYTES(LB), .MAX_LEN(ML), .DEPTH(DP), .MAX_OUT(MO)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .req_status(req_status), .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
      .mreq_store(mreq_store), .mreq_addr(mreq_addr), .mreq_line(mreq_line),
      .mreq_len(mreq_len), .mreq_data(mreq_data), .mrsp_valid(mrsp_valid),
      .mrsp_line(mrsp_line), .mrsp_data(mrsp_data), .done_valid(done_valid),
      .done_write(done_write), .done_line(done_line), .done_len(done_len),
      .done_rdata(done_rdata), .stray_err(stray_err));

   function automatic logic [7:0] wb(input int i, input int s);
      return 8'(i * 13 + 5 + s * 29);
   endfunction
   function automatic logic [7:0] mb(input int a);
      return 8'(a * 7 + 3) ^ 8'h5A;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [191:0] act, input logic [191:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // drive a request for one cycle; returns at the following negedge
   task automatic send(input bit w, input int addr, input int len,
                       input logic [DW-1:0] wd, output logic [1:0] st);
      req_valid = 1'b1; req_write = w; req_addr = AW'(addr);
      req_len = LENW'(len); req_wdata = wd;
      #1 st = req_status;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic respond(input int line);
      logic [LW-1:0] d;
      for (int j = 0; j < LB; j++) d[j*8 +: 8] = mb(line + j);
      mrsp_valid = 1'b1; mrsp_line = AW'(line); mrsp_data = d;
      @(negedge clk);
      mrsp_valid = 1'b0;
   endtask

   task automatic check_read_done(input int addr, input int len, input string rq);
      logic [DW-1:0] e;
      e = '0;
      for (int i = 0; i < len; i++) e[i*8 +: 8] = mb(addr + i);
      chk(done_valid == 1'b1, "R9", "done pulse", done_valid, 1);
      chk(done_line == AW'(addr - addr % LB), "R9", "done line", done_line, addr - addr % LB);
      chk(done_rdata == e, rq, "read gather", done_rdata, e);
   endtask

   task automatic run_req(input bit w, input int addr, input int len, input int seed, input bit stall);
      logic [DW-1:0] wd;
      logic [LW-1:0] epay, snap_d;
      logic [AW-1:0] snap_a;
      logic [1:0] st;
      int comp, off, clen, caddr, cline;
      wd = '0;
      for (int i = 0; i < len; i++) wd[i*8 +: 8] = wb(i, seed);
      send(w, addr, len, wd, st);
      chk(st == 2'd0, "R1", "accept status", st, 0);
      comp = 0;
      while (comp < len) begin
         for (int t = 0; t < 20 && !mreq_valid; t++) @(negedge clk);
         chk(mreq_valid == 1'b1, "R4", "chunk offered", mreq_valid, 1);
         off = (comp == 0) ? addr % LB : 0;
         clen = len - comp;
         if (clen > LB - off) clen = LB - off;
         caddr = addr + comp;
         cline = caddr - caddr % LB;
         epay = '0;
         if (w) for (int j = off; j < off + clen; j++) epay[j*8 +: 8] = wb(comp + j - off, seed);
         if (stall) begin
            snap_a = mreq_addr; snap_d = mreq_data;
            @(negedge clk);
            chk(mreq_valid && mreq_addr == snap_a && mreq_data == snap_d, "R11",
                "stall hold", mreq_addr, snap_a);
         end
         chk(mreq_addr == AW'(caddr), (comp == 0) ? "R4" : "R5", "chunk addr", mreq_addr, caddr);
         chk(mreq_len == LENW'(clen), (comp == 0) ? "R4" : "R5", "chunk len", mreq_len, clen);
         chk(mreq_line == AW'(cline), "R6", "chunk line", mreq_line, cline);
         chk(mreq_store == w, "R6", "store flag", mreq_store, w);
         chk(mreq_data == epay, "R7", "payload", mreq_data, epay);
         mreq_ready = 1'b1;
         @(negedge clk);
         mreq_ready = 1'b0;
         chk(mreq_valid == 1'b0, "R10", "single chunk in flight", mreq_valid, 0);
         respond(cline);
         comp += clen;
         if (comp == len) begin
            chk(done_write == w, "R9", "done dir", done_write, w);
            chk(done_len == LENW'(len), "R9", "done len", done_len, len);
            if (w) chk(done_valid == 1'b1, "R9", "done pulse", done_valid, 1);
            else   check_read_done(addr, len, "R8");
            @(negedge clk);
            chk(done_valid == 1'b0, "R9", "pulse one cycle", done_valid, 0);
         end else begin
            chk(done_valid == 1'b0, "R9", "no early done", done_valid, 0);
         end
      end
   endtask

   initial begin
      #(5ns * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [1:0] st;
      repeat (3) @(negedge clk);
      chk(mreq_valid == 1'b0, "R10", "reset offer", mreq_valid, 0);
      chk(done_valid == 1'b0, "R9", "reset done", done_valid, 0);
      chk(stray_err == 1'b0, "R13", "reset flag", stray_err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: bad lengths
      send(1'b0, 'h100, 0, '0, st);
      chk(st == 2'd3, "R3", "zero length", st, 3);
      chk(mreq_valid == 1'b0, "R3", "no chunk for zero", mreq_valid, 0);
      send(1'b1, 'h100, ML + 1, '0, st);
      chk(st == 2'd3, "R3", "over length", st, 3);
      chk(mreq_valid == 1'b0, "R3", "no chunk for over", mreq_valid, 0);

      // sweep every offset and length, both directions
      for (int w = 0; w < 2; w++)
         for (int off = 0; off < LB; off++)
            for (int len = 1; len <= ML; len++)
               run_req(w[0], 'h200 + ((len * 3 + w) % 16) * LB + off, len, off + len, (len % 3) == 0);

      // R1, R2, R3 priority, R12 order
      send(1'b0, 'h402, 4, '0, st);
      chk(st == 2'd0, "R1", "A accepted", st, 0);
      send(1'b0, 'h480, 8, '0, st);
      chk(st == 2'd0, "R1", "B accepted", st, 0);
      send(1'b0, 'h405, 1, '0, st);
      chk(st == 2'd2, "R2", "alias refused", st, 2);
      send(1'b0, 'h500, 3, '0, st);
      chk(st == 2'd0, "R1", "C accepted", st, 0);
      send(1'b0, 'h600, 2, '0, st);
      chk(st == 2'd1, "R1", "full refused", st, 1);
      send(1'b0, 'h404, 2, '0, st);
      chk(st == 2'd1, "R3", "full before alias", st, 1);
      send(1'b0, 'h600, 0, '0, st);
      chk(st == 2'd3, "R3", "badlen before full", st, 3);
      chk(mreq_addr == AW'('h402), "R12", "lowest first", mreq_addr, 'h402);
      mreq_ready = 1'b1;
      @(negedge clk);
      chk(mreq_addr == AW'('h480), "R12", "second", mreq_addr, 'h480);
      @(negedge clk);
      chk(mreq_addr == AW'('h500), "R12", "third", mreq_addr, 'h500);
      @(negedge clk);
      mreq_ready = 1'b0;
      chk(mreq_valid == 1'b0, "R10", "all in flight", mreq_valid, 0);
      respond('h500);
      check_read_done('h500, 3, "R8");
      respond('h400);
      check_read_done('h402, 4, "R8");
      run_req(1'b0, 'h401, 1, 0, 1'b0);
      respond('h480);
      check_read_done('h480, 8, "R8");

      // R13: unmatched response
      @(negedge clk);
      respond('h7F8);
      chk(stray_err == 1'b1, "R13", "flag set", stray_err, 1);
      chk(done_valid == 1'b0, "R13", "no completion", done_valid, 0);
      chk(mreq_valid == 1'b0, "R13", "no chunk", mreq_valid, 0);
      repeat (3) @(negedge clk);
      chk(stray_err == 1'b1, "R13", "flag sticky", stray_err, 1);
      run_req(1'b1, 'h7F8, 5, 7, 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule